// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block decides when an exception is actually taken in a core whose instructions retire in program order. Dispatch and execution units report faults tagged with a 6-bit, wrapping program-order sequence number. The block keeps the oldest such report in a single pending slot. It takes that exception only once the faulting instruction has become the oldest uncompleted one, and it never lets the faulting instruction itself retire.

The retire stage presents the oldest instruction each cycle. The block either allows it to complete or turns a fault found at completion into an exception. In the second case the completion fault wins over any younger pending report, and that report is dropped. After an instruction completes while trace is enabled, a trace exception follows it. On entry the block loads a resume address and a saved copy of the live status word. It then clears the trace and interrupt enables, and emits a one-cycle fetch redirect to the cause's vector together with a pipeline flush. A return-from-interrupt request restores the status word and redirects fetch to the saved resume address.

Top module: `exc_commit_ctrl`

## Requirements
- R1: After reset, the oldest-uncompleted pointer is 0, the status word, saved status, resume address and cause are 0, and no redirect, flush or exception pulse is asserted.
- R2: A pending fault is taken only in a cycle where its sequence number equals the oldest-uncompleted pointer. Younger retirements before that cycle complete normally.
- R3: `rt_commit` is high only for a retiring instruction that is completed. It is low in any cycle where that instruction's own fault is taken. The pointer advances by exactly one per completion and otherwise holds.
- R4: If the retiring instruction raises a fault (`rt_exc`) while a younger report is pending, the retiring fault is taken and the pending report is discarded for good.
- R5: Of two reports, the one whose sequence number is fewer steps after the pointer (modulo 64) is kept. A younger or equal-age report arriving while one is pending is ignored.
- R6: When an instruction completes with status bit 0 (trace enable) set, a trace exception (cause 7) is taken in the same cycle, with resume address equal to that instruction's address plus 4.
- R7: When several causes hit the same instruction, the lower cause code wins. A completion fault or a due pending fault suppresses trace for that instruction.
- R8: The resume address is the faulting instruction's address, except for cause 4 (system call) and cause 7 (trace), where it is that address plus 4.
- R9: On exception entry, the saved status receives the status word as it was before entry. Status bits 0 (trace enable) and 1 (interrupt enable) are then cleared, and the other bits are kept.
- R10: An exception drives `redir_v`, `flush` and `exc_taken` high for exactly one cycle, with `redir_pc` = 0x1000 + (cause+1)×0x100 and `take_code` = cause. Cause codes: 0 illegal, 1 data access, 2 misalignment, 3 emulation, 4 system call, 5 data-translation miss, 6 breakpoint, 7 trace.
- R11: A return request with no exception taken that cycle copies the saved status into the status word. It also drops any pending report and pulses `redir_v` and `flush` with `redir_pc` = resume address. An exception taken in the same cycle overrides it.
- R12: In the cycle that `flush` is high, reports, retirements and return requests have no effect.
- R13: A status write takes effect on the next edge when no exception or return occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rep_valid | input | 1 | Fault report from dispatch/execute |
| rep_seq | input | 6 | Sequence number of the reported instruction |
| rep_code | input | 3 | Cause code of the report |
| rep_pc | input | 32 | Address of the reported instruction |
| rt_valid | input | 1 | Oldest instruction is presented for retirement |
| rt_pc | input | 32 | Address of the retiring instruction |
| rt_exc | input | 1 | Retiring instruction raises a fault on completion |
| rt_code | input | 3 | Cause code of that fault |
| rfi_req | input | 1 | Return-from-interrupt request |
| stat_we | input | 1 | Status word write enable |
| stat_wd | input | 8 | Status word write data |
| rt_commit | output | 1 | Retiring instruction completes this cycle |
| head_seq | output | 6 | Oldest-uncompleted sequence number |
| exc_taken | output | 1 | One-cycle pulse: exception entered |
| take_code | output | 3 | Cause of the last exception taken |
| redir_v | output | 1 | One-cycle fetch redirect |
| redir_pc | output | 32 | Redirect target |
| flush | output | 1 | One-cycle kill of younger in-flight instructions |
| stat | output | 8 | Live status word |
| saved_stat | output | 8 | Saved status word |
| resume_pc | output | 32 | Resume address |

## Verification
Directed sequences try the commit decision under isolated patterns. A report that must wait behind older completions separates deferral from immediate taking. A completion fault beneath a younger report shows that the report is discarded rather than queued. A system call and a trace separate the two resume-address rules. Reports placed across the 63-to-0 wrap check that modular ageing keeps the truly older fault, and inputs placed in the flush cycle confirm that they are ignored. Several thousand random cycles then mix retirements, completion faults, out-of-order reports, status writes and returns. Each cycle is checked against a bench model, which catches wrong arbitration among trace, pending faults, completion faults and returns.

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl #(
  parameter int              SEQ_W      = 6,
  parameter int              AW         = 32,
  parameter int              SW         = 8,
  parameter int              TE_BIT     = 0,
  parameter int              IE_BIT     = 1,
  parameter int              INSN_BYTES = 4,
  parameter logic [AW-1:0]   VEC_BASE   = 32'h0000_1000,
  parameter logic [AW-1:0]   VEC_STEP   = 32'h0000_0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rep_valid,
  input  logic [SEQ_W-1:0] rep_seq,
  input  logic [2:0]       rep_code,
  input  logic [AW-1:0]    rep_pc,
  input  logic             rt_valid,
  input  logic [AW-1:0]    rt_pc,
  input  logic             rt_exc,
  input  logic [2:0]       rt_code,
  input  logic             rfi_req,
  input  logic             stat_we,
  input  logic [SW-1:0]    stat_wd,
  output logic             rt_commit,
  output logic [SEQ_W-1:0] head_seq,
  output logic             exc_taken,
  output logic [2:0]       take_code,
  output logic             redir_v,
  output logic [AW-1:0]    redir_pc,
  output logic             flush,
  output logic [SW-1:0]    stat,
  output logic [SW-1:0]    saved_stat,
  output logic [AW-1:0]    resume_pc
);
  localparam logic [2:0] C_SCALL = 3'd4;
  localparam logic [2:0] C_TRACE = 3'd7;
  localparam logic [SW-1:0] EN_MASK = SW'(1) << TE_BIT | SW'(1) << IE_BIT;

  logic [SEQ_W-1:0] head_q, pseq_q;
  logic             pv_q;
  logic [2:0]       pcode_q;
  logic [AW-1:0]    ppc_q;

  logic live, pend_due, rt_live, rt_fault, trace_hit, take, rfi_go, rep_win;
  logic [2:0]       sel_code;
  logic [AW-1:0]    sel_pc, sel_res, sel_vec;
  logic [SEQ_W-1:0] rep_age, pend_age;

  assign live      = !flush;
  assign pend_due  = pv_q && (pseq_q == head_q) && live;
  assign rt_live   = rt_valid && live;
  assign rt_fault  = rt_live && rt_exc;
  assign rt_commit = rt_live && !rt_exc && !pend_due;
  assign trace_hit = rt_commit && stat[TE_BIT];
  assign take      = pend_due || rt_fault || trace_hit;
  assign rfi_go    = rfi_req && live && !take;

  assign rep_age  = rep_seq - head_q;
  assign pend_age = pseq_q - head_q;
  assign rep_win  = rep_valid && live && !take && !rfi_go &&
                    (!pv_q || rep_age < pend_age);

  always_comb begin
    if (pend_due && rt_fault) begin
      sel_code = (rt_code < pcode_q) ? rt_code : pcode_q;
      sel_pc   = ppc_q;
    end else if (pend_due) begin
      sel_code = pcode_q;
      sel_pc   = ppc_q;
    end else if (rt_fault) begin
      sel_code = rt_code;
      sel_pc   = rt_pc;
    end else begin
      sel_code = C_TRACE;
      sel_pc   = rt_pc;
    end
  end

  assign sel_res = (sel_code == C_SCALL || sel_code == C_TRACE) ?
                   sel_pc + AW'(INSN_BYTES) : sel_pc;
  assign sel_vec = VEC_BASE + (AW'(sel_code) + AW'(1)) * VEC_STEP;

  assign head_seq = head_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q     <= '0;
      pv_q       <= 1'b0;
      pseq_q     <= '0;
      pcode_q    <= '0;
      ppc_q      <= '0;
      exc_taken  <= 1'b0;
      take_code  <= '0;
      redir_v    <= 1'b0;
      redir_pc   <= '0;
      flush      <= 1'b0;
      stat       <= '0;
      saved_stat <= '0;
      resume_pc  <= '0;
    end else begin
      exc_taken <= take;
      redir_v   <= take || rfi_go;
      flush     <= take || rfi_go;
      if (rt_commit) head_q <= head_q + SEQ_W'(1);
      if (take) begin
        take_code  <= sel_code;
        redir_pc   <= sel_vec;
        resume_pc  <= sel_res;
        saved_stat <= stat;
        stat       <= stat & ~EN_MASK;
        pv_q       <= 1'b0;
      end else if (rfi_go) begin
        redir_pc <= resume_pc;
        stat     <= saved_stat;
        pv_q     <= 1'b0;
      end else begin
        if (stat_we) stat <= stat_wd;
        if (rep_win) begin
          pv_q    <= 1'b1;
          pseq_q  <= rep_seq;
          pcode_q <= rep_code;
          ppc_q   <= rep_pc;
        end
      end
    end
  end
endmodule

module exc_commit_ctrl_chk #(
  parameter int            SEQ_W    = 6,
  parameter int            AW       = 32,
  parameter int            SW       = 8,
  parameter int            TE_BIT   = 0,
  parameter int            IE_BIT   = 1,
  parameter logic [AW-1:0] VEC_BASE = 32'h0000_1000,
  parameter logic [AW-1:0] VEC_STEP = 32'h0000_0100
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    rt_pc,
  input logic             rt_commit,
  input logic [SEQ_W-1:0] head_seq,
  input logic             exc_taken,
  input logic [2:0]       take_code,
  input logic             redir_v,
  input logic [AW-1:0]    redir_pc,
  input logic             flush,
  input logic [SW-1:0]    stat,
  input logic [SW-1:0]    saved_stat,
  input logic [AW-1:0]    resume_pc
);
  AST_REDIR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    redir_v |=> !redir_v); // R10
  AST_EXC_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> (flush && redir_v)); // R10
  AST_VECTOR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> redir_pc == VEC_BASE + (AW'(take_code) + AW'(1)) * VEC_STEP); // R10
  AST_NO_COMMIT_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !rt_commit); // R12
  AST_HEAD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    rt_commit |=> head_seq == SEQ_W'($past(head_seq) + SEQ_W'(1))); // R3
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_commit |=> $stable(head_seq)); // R3
  AST_ENTRY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> (!stat[TE_BIT] && !stat[IE_BIT])); // R9
  AST_ENTRY_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_taken) |-> saved_stat == $past(stat)); // R9
  AST_TRACE_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_taken && take_code == 3'd7) |-> resume_pc == $past(rt_pc) + AW'(4)); // R6
endmodule

bind exc_commit_ctrl exc_commit_ctrl_chk #(
  .SEQ_W(SEQ_W), .AW(AW), .SW(SW), .TE_BIT(TE_BIT), .IE_BIT(IE_BIT),
  .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rt_pc(rt_pc), .rt_commit(rt_commit),
  .head_seq(head_seq), .exc_taken(exc_taken), .take_code(take_code),
  .redir_v(redir_v), .redir_pc(redir_pc), .flush(flush), .stat(stat),
  .saved_stat(saved_stat), .resume_pc(resume_pc)
);

// File: tb/tb_exc_commit_ctrl.sv
module tb_exc_commit_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        rep_valid = 0, rt_valid = 0, rt_exc = 0, rfi_req = 0, stat_we = 0;
  logic [5:0]  rep_seq = 0;
  logic [2:0]  rep_code = 0, rt_code = 0;
  logic [31:0] rep_pc = 0, rt_pc = 0;
  logic [7:0]  stat_wd = 0;
  logic        rt_commit, exc_taken, redir_v, flush;
  logic [5:0]  head_seq;
  logic [2:0]  take_code;
  logic [31:0] redir_pc, resume_pc;
  logic [7:0]  stat, saved_stat;

  exc_commit_ctrl dut (
    .clk(clk), .rst_n(rst_n), .rep_valid(rep_valid), .rep_seq(rep_seq),
    .rep_code(rep_code), .rep_pc(rep_pc), .rt_valid(rt_valid), .rt_pc(rt_pc),
    .rt_exc(rt_exc), .rt_code(rt_code), .rfi_req(rfi_req), .stat_we(stat_we),
    .stat_wd(stat_wd), .rt_commit(rt_commit), .head_seq(head_seq),
    .exc_taken(exc_taken), .take_code(take_code), .redir_v(redir_v),
    .redir_pc(redir_pc), .flush(flush), .stat(stat), .saved_stat(saved_stat),
    .resume_pc(resume_pc)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  logic [5:0]  m_head = 0, m_pseq = 0;
  logic        m_pv = 0, m_flush = 0, m_rv = 0, m_exc = 0;
  logic [2:0]  m_pcode = 0, m_code = 0;
  logic [31:0] m_ppc = 0, m_rpc = 0, m_resume = 0;
  logic [7:0]  m_stat = 0, m_saved = 0;
  logic        e_commit;

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] vec_of(logic [2:0] c);
    return 32'h1000 + (32'(c) + 1) * 32'h100;
  endfunction

  function automatic logic [31:0] pc_of(logic [5:0] s);
    return 32'h4000 + 32'(s) * 4;
  endfunction

  // one cycle: inputs already driven after a falling edge
  task automatic step(string tag);
    logic live, pdue, rl, rf, tr, tk, rfi_go, win;
    logic [2:0] c;
    logic [31:0] p;
    logic [5:0] ra, pa;
    #1;
    live = !m_flush;
    pdue = m_pv && m_pseq == m_head && live;
    rl = rt_valid && live;
    rf = rl && rt_exc;
    e_commit = rl && !rt_exc && !pdue;
    tr = e_commit && m_stat[0];
    tk = pdue || rf || tr;
    rfi_go = rfi_req && live && !tk;
    if (pdue && rf) begin c = (rt_code < m_pcode) ? rt_code : m_pcode; p = m_ppc; end
    else if (pdue) begin c = m_pcode; p = m_ppc; end
    else if (rf) begin c = rt_code; p = rt_pc; end
    else begin c = 3'd7; p = rt_pc; end
    ra = rep_seq - m_head;
    pa = m_pseq - m_head;
    win = rep_valid && live && !tk && !rfi_go && (!m_pv || ra < pa);
    chk((tag == "") ? "R3" : tag, "rt_commit", 32'(rt_commit), 32'(e_commit));
    @(posedge clk);
    m_exc = tk;
    m_rv = tk || rfi_go;
    m_flush = tk || rfi_go;
    if (e_commit) m_head = m_head + 1;
    if (tk) begin
      m_code = c;
      m_rpc = vec_of(c);
      m_resume = (c == 3'd4 || c == 3'd7) ? p + 4 : p;
      m_saved = m_stat;
      m_stat = m_stat & 8'hFC;
      m_pv = 0;
    end else if (rfi_go) begin
      m_rpc = m_resume;
      m_stat = m_saved;
      m_pv = 0;
    end else begin
      if (stat_we) m_stat = stat_wd;
      if (win) begin m_pv = 1; m_pseq = rep_seq; m_pcode = rep_code; m_ppc = rep_pc; end
    end
    @(negedge clk);
    chk((tag == "") ? "R2" : tag, "exc_taken", 32'(exc_taken), 32'(m_exc));
    chk((tag == "") ? "R10" : tag, "redir_v", 32'(redir_v), 32'(m_rv));
    chk((tag == "") ? "R10" : tag, "flush", 32'(flush), 32'(m_flush));
    chk((tag == "") ? "R10" : tag, "take_code", 32'(take_code), 32'(m_code));
    chk((tag == "") ? "R11" : tag, "redir_pc", redir_pc, m_rpc);
    chk((tag == "") ? "R8" : tag, "resume_pc", resume_pc, m_resume);
    chk((tag == "") ? "R9" : tag, "stat", 32'(stat), 32'(m_stat));
    chk((tag == "") ? "R9" : tag, "saved_stat", 32'(saved_stat), 32'(m_saved));
    chk((tag == "") ? "R3" : tag, "head_seq", 32'(head_seq), 32'(m_head));
    rep_valid = 0; rt_valid = 0; rt_exc = 0; rfi_req = 0; stat_we = 0;
  endtask

  task automatic retire(string tag);
    rt_valid = 1; rt_pc = pc_of(m_head); step(tag);
  endtask

  task automatic report(logic [5:0] s, logic [2:0] c);
    rep_valid = 1; rep_seq = s; rep_code = c; rep_pc = pc_of(s);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step("");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1", "head_seq", 32'(head_seq), 0);
    chk("R1", "redir_v", 32'(redir_v), 0);
    chk("R1", "flush", 32'(flush), 0);
    chk("R1", "exc_taken", 32'(exc_taken), 0);
    chk("R1", "stat", 32'(stat), 0);
    chk("R1", "saved_stat", 32'(saved_stat), 0);
    chk("R1", "resume_pc", resume_pc, 0);
    @(negedge clk);

    // R2: data fault on seq 2 waits for seq 0 and 1
    report(6'd2, 3'd1); step("R2");
    retire("R2");
    chk("R2", "no early take", 32'(exc_taken), 0);
    retire("R2");
    chk("R2", "no early take", 32'(exc_taken), 0);
    retire("R2");
    chk("R2", "taken at head", 32'(exc_taken), 1);
    chk("R3", "faulting insn held", 32'(head_seq), 2);
    idle(1);

    // R4: completion fault on head beats younger pending report
    report(6'd4, 3'd2); step("R4");
    rt_exc = 1; rt_code = 3'd1; retire("R4");
    chk("R4", "older cause", 32'(take_code), 1);
    idle(1);
    for (int k = 0; k < 4; k++) retire("R4");
    chk("R4", "discarded report", 32'(head_seq), 6);

    // R8: system call resumes at next instruction
    report(m_head, 3'd4); step("R8");
    step("R8");
    chk("R8", "syscall resume", resume_pc, pc_of(6'd6) + 4);
    idle(1);

    // R13 / R6 / R9: enable trace, trace after a completion
    stat_we = 1; stat_wd = 8'h13; step("R13");
    chk("R13", "stat write", 32'(stat), 32'h13);
    retire("R6");
    chk("R6", "trace code", 32'(take_code), 7);
    chk("R6", "trace resume", resume_pc, pc_of(6'd6) + 4);
    chk("R9", "saved", 32'(saved_stat), 32'h13);
    chk("R9", "masked", 32'(stat), 32'h10);
    step("R12");

    // R11: return restores status and redirects
    rfi_req = 1; step("R11");
    chk("R11", "return target", redir_pc, pc_of(6'd7));
    chk("R11", "restored", 32'(stat), 32'h13);
    step("R12");

    // R7: trace enabled, completion fault wins over trace
    rt_exc = 1; rt_code = 3'd5; retire("R7");
    chk("R7", "fault over trace", 32'(take_code), 5);
    step("R12");
    rfi_req = 1; step("R11");
    step("R12");
    stat_we = 1; stat_wd = 8'h02; step("R13");
    // R7: pending code 3 and completion code 1 on the same instruction
    report(m_head, 3'd3); step("R7");
    rt_exc = 1; rt_code = 3'd1; retire("R7");
    chk("R7", "lower code", 32'(take_code), 1);
    step("R12");

    // R11: exception beats a simultaneous return
    report(m_head, 3'd6); step("R11");
    rfi_req = 1; step("R11");
    chk("R11", "exc over return", 32'(exc_taken), 1);
    step("R12");

    // R5: modular age across the wrap
    while (m_head != 6'd60) retire("R5");
    report(6'd1, 3'd0); step("R5");
    report(6'd62, 3'd2); step("R5");
    report(6'd63, 3'd3); step("R5");
    retire("R5"); retire("R5");
    step("R5");
    chk("R5", "oldest kept", 32'(take_code), 2);
    chk("R5", "oldest pc", resume_pc, pc_of(6'd62));

    // R12: inputs during flush ignored
    report(6'd63, 3'd3); rt_valid = 1; rt_pc = pc_of(m_head); rfi_req = 1; step("R12");
    chk("R12", "no commit in flush", 32'(head_seq), 62);
    step("R12");
    chk("R12", "no take from flush report", 32'(exc_taken), 0);
    idle(2);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      rt_valid = ($urandom_range(0, 99) < 55);
      rt_pc = pc_of(m_head);
      rt_exc = ($urandom_range(0, 99) < 8);
      rt_code = 3'($urandom_range(0, 6));
      if ($urandom_range(0, 99) < 25) report(m_head + 6'($urandom_range(1, 7)), 3'($urandom_range(0, 6)));
      rfi_req = ($urandom_range(0, 99) < 4);
      stat_we = ($urandom_range(0, 99) < 5);
      stat_wd = 8'($urandom_range(0, 255));
      step("");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule